// File: doc/BRIEF.md
# Chained Hash Table Probe Engine

This block runs the probe side of an in-memory hash join. Each incoming tuple (32-bit key, payload) becomes its own thread. The engine hashes the key and reads that bucket's head pointer from memory. It then follows the bucket's linked list one node at a time, comparing each stored key with the probe key. Every node whose key matches produces a joined tuple on the output stream. Many threads can wait on memory at the same time, so memory latency is hidden by overlapping independent tuples rather than by caching.

There is one datapath stage. A thread whose memory response has come back re-enters that stage to emit a match, to request its next node, or to retire. Such recycled threads always win over new tuples, so intake stalls while any recycled thread is waiting its turn. The memory port is a request/response pair with variable latency. Responses may come back in any order and are matched to threads by a tag. A node occupies 12 bytes: key, build payload, next pointer. A null pointer is the value 0.

Top module: `hash_probe_engine`

## Requirements
- R1: When a tuple is accepted (in_valid and in_ready), a head read is issued in the same cycle. It has mem_req_node=0, the tag of a free thread, and mem_req_addr = TABLE_BASE + 4*h. Here h is bits [31:32-HASH_BITS] of the low 32 bits of in_key * 32'h9E3779B1.
- R2: A head response of 0 drops the tuple. No output is produced and its thread becomes free.
- R3: A nonzero head or next pointer causes a node read with mem_req_node=1 at that byte address. The node response carries the stored key in bits [31:0], the build payload in bits [63:32] and the next pointer in bits [95:64].
- R4: A node whose key equals the probe key yields one output: out_key = probe key, out_probe_pay = probe payload, out_build_pay = node payload. A node whose key differs yields nothing.
- R5: Every matching node on a chain yields exactly one output, including duplicate keys on the same chain.
- R6: A thread retires on reading a next pointer of 0, after any output from that node has been accepted. Retired threads can be reused by later tuples.
- R7: In the cycle after a response is delivered, in_ready is low, because recycled threads take priority over new tuples.
- R8: At most THREADS tuples are outstanding. With all threads busy, in_ready stays low.
- R9: Responses returning in any order are routed by mem_rsp_tag to the thread that issued the request.
- R10: After reset, out_valid and mem_req_valid are low, and in_ready is high when mem_req_ready is high.
- R11: While out_valid is high and out_ready is low, out_valid stays high and all three output fields hold their values.
- R12: in_ready is low whenever mem_req_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Probe tuple offered |
| in_ready | output | 1 | Probe tuple accepted this cycle |
| in_key | input | 32 | Probe key |
| in_pay | input | PAY_W | Probe payload |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | PTR_W | Byte address to read |
| mem_req_node | output | 1 | 1: 12-byte node read, 0: 4-byte head read |
| mem_req_tag | output | TAG_W | Thread issuing the request |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_tag | input | TAG_W | Thread the data belongs to |
| mem_rsp_data | input | 32+PAY_W+PTR_W | Head pointer in low bits, or node {next, payload, key} |
| out_valid | output | 1 | Joined tuple available |
| out_ready | input | 1 | Consumer accepts joined tuple |
| out_key | output | 32 | Join key |
| out_probe_pay | output | PAY_W | Payload of the probe tuple |
| out_build_pay | output | PAY_W | Payload of the matched node |

## Verification
The bench goes after chains that hold the same key several times. An engine that stopped at the first hit, or retired before emitting at the last node, would leave expected joins unmatched. It probes a key that maps to an empty bucket; a design that treated 0 as a node address would issue a stray node read or emit garbage. It returns responses out of order under random request and output back-pressure, so tag mixups, output fields that change while stalled, and new tuples slipping in ahead of a recycled thread all show up. It also freezes memory until every thread is busy, which exposes an engine that overruns its context table or never frees a slot.

// File: rtl/hash_probe_engine.sv
module hash_probe_engine #(
  parameter int THREADS = 8,
  parameter int HASH_BITS = 12,
  parameter int PAY_W = 32,
  parameter int PTR_W = 32,
  parameter logic [PTR_W-1:0] TABLE_BASE = '0,
  localparam int TAG_W = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int NODE_W = 32 + PAY_W + PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_key,
  input  logic [PAY_W-1:0]  in_pay,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PTR_W-1:0]  mem_req_addr,
  output logic              mem_req_node,
  output logic [TAG_W-1:0]  mem_req_tag,
  input  logic              mem_rsp_valid,
  input  logic [TAG_W-1:0]  mem_rsp_tag,
  input  logic [NODE_W-1:0] mem_rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_key,
  output logic [PAY_W-1:0]  out_probe_pay,
  output logic [PAY_W-1:0]  out_build_pay
);
  localparam logic [31:0] HASH_MULT = 32'h9E3779B1;

  typedef enum logic [1:0] {S_FREE, S_WAIT, S_HEAD, S_NODE} st_t;

  st_t              st     [THREADS];
  logic [31:0]      c_key  [THREADS];
  logic [PAY_W-1:0] c_pay  [THREADS];
  logic [31:0]      c_nkey [THREADS];
  logic [PAY_W-1:0] c_npay [THREADS];
  logic [PTR_W-1:0] c_next [THREADS];
  logic             c_node [THREADS];
  logic             c_sent [THREADS];

  logic             free_any, rdy_any;
  logic [TAG_W-1:0] free_idx, rdy_low, sel;
  logic             hold_q;
  logic [TAG_W-1:0] hold_idx;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    rdy_any  = 1'b0;
    rdy_low  = '0;
    for (int i = THREADS - 1; i >= 0; i--) begin
      if (st[i] == S_FREE) begin
        free_any = 1'b1;
        free_idx = TAG_W'(i);
      end
      if (st[i] == S_HEAD || st[i] == S_NODE) begin
        rdy_any = 1'b1;
        rdy_low = TAG_W'(i);
      end
    end
  end

  assign sel = hold_q ? hold_idx : rdy_low;

  logic [31:0]          hash_prod;
  logic [HASH_BITS-1:0] bucket;
  logic [PTR_W-1:0]     head_addr;
  assign hash_prod = in_key * HASH_MULT;
  assign bucket    = hash_prod[31 -: HASH_BITS];
  assign head_addr = TABLE_BASE + (PTR_W'(bucket) << 2);

  logic sel_head, sel_node, is_null, hit, emit_pend;
  logic walk_req, new_req, drop, issue, mark_sent;

  assign sel_head  = rdy_any && st[sel] == S_HEAD;
  assign sel_node  = rdy_any && st[sel] == S_NODE;
  assign is_null   = c_next[sel] == '0;
  assign hit       = c_nkey[sel] == c_key[sel];
  assign emit_pend = sel_node && hit && !c_sent[sel];

  assign walk_req  = (sel_head || (sel_node && !emit_pend)) && !is_null;
  assign new_req   = !rdy_any && in_valid && free_any;
  assign drop      = is_null && (sel_head || (sel_node && (!emit_pend || out_ready)));
  assign issue     = walk_req && mem_req_ready;
  assign mark_sent = emit_pend && out_ready && !is_null;

  assign in_ready      = !rdy_any && free_any && mem_req_ready;
  assign mem_req_valid = walk_req || new_req;
  assign mem_req_node  = rdy_any;
  assign mem_req_addr  = rdy_any ? c_next[sel] : head_addr;
  assign mem_req_tag   = rdy_any ? sel : free_idx;

  assign out_valid     = emit_pend;
  assign out_key       = c_key[sel];
  assign out_probe_pay = c_pay[sel];
  assign out_build_pay = c_npay[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q   <= 1'b0;
      hold_idx <= '0;
    end else begin
      hold_q   <= rdy_any && !(drop || issue);
      hold_idx <= sel;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < THREADS; i++) begin
      if (!rst_n) begin
        st[i]     <= S_FREE;
        c_node[i] <= 1'b0;
        c_sent[i] <= 1'b0;
        c_key[i]  <= '0;
        c_pay[i]  <= '0;
        c_nkey[i] <= '0;
        c_npay[i] <= '0;
        c_next[i] <= '0;
      end else begin
        if (in_valid && in_ready && free_idx == TAG_W'(i)) begin
          st[i]     <= S_WAIT;
          c_key[i]  <= in_key;
          c_pay[i]  <= in_pay;
          c_node[i] <= 1'b0;
          c_sent[i] <= 1'b0;
        end
        if (mem_rsp_valid && mem_rsp_tag == TAG_W'(i)) begin
          if (c_node[i]) begin
            st[i]     <= S_NODE;
            c_nkey[i] <= mem_rsp_data[31:0];
            c_npay[i] <= mem_rsp_data[32 +: PAY_W];
            c_next[i] <= mem_rsp_data[32 + PAY_W +: PTR_W];
          end else begin
            st[i]     <= S_HEAD;
            c_next[i] <= mem_rsp_data[PTR_W-1:0];
          end
        end
        if (rdy_any && sel == TAG_W'(i)) begin
          if (drop) begin
            st[i] <= S_FREE;
          end else if (issue) begin
            st[i]     <= S_WAIT;
            c_node[i] <= 1'b1;
            c_sent[i] <= 1'b0;
          end else if (mark_sent) begin
            c_sent[i] <= 1'b1;
          end
        end
      end
    end
  end

  a_r4_out_from_node: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> st[sel] == S_NODE);

  a_r11_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_key)
      && $stable(out_probe_pay) && $stable(out_build_pay));

  a_r3_node_not_null: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_node |-> mem_req_addr != '0);

  a_r7_recycle_first: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> !out_valid && !mem_req_node);

  a_r9_rsp_to_waiter: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> st[mem_rsp_tag] == S_WAIT);

  a_r6_emit_before_walk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_node |-> !out_valid);

endmodule

// File: tb/test_hash_probe_engine.sv
`timescale 1ns/1ps
module test_hash_probe_engine;
  localparam int THREADS = 8;
  localparam int HB = 4;
  localparam int NB = 1 << HB;
  localparam int NN = 48;
  localparam logic [31:0] TBASE = 32'h100;
  localparam logic [31:0] NBASE = 32'h1000;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [31:0] in_key = 0, in_pay = 0;
  logic mem_req_valid, mem_req_ready, mem_req_node;
  logic [31:0] mem_req_addr;
  logic [2:0] mem_req_tag;
  logic mem_rsp_valid;
  logic [2:0] mem_rsp_tag;
  logic [95:0] mem_rsp_data;
  logic out_valid, out_ready;
  logic [31:0] out_key, out_probe_pay, out_build_pay;

  always #2.5 clk = ~clk;

  hash_probe_engine #(.THREADS(THREADS), .HASH_BITS(HB), .PAY_W(32), .PTR_W(32),
    .TABLE_BASE(TBASE)) i_hash_probe_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_key(in_key), .in_pay(in_pay), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_req_node(mem_req_node), .mem_req_tag(mem_req_tag),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag),
    .mem_rsp_data(mem_rsp_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_key(out_key), .out_probe_pay(out_probe_pay), .out_build_pay(out_build_pay));

  int checks = 0, fails = 0, n_out = 0;
  logic [31:0] head_t [NB];
  logic [31:0] nk [NN], np [NN], nn [NN];
  int n_nodes = 0;
  logic [95:0] expq [$];
  bit rdy_rand = 0, out_rand = 0, freeze = 0;

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [HB-1:0] hsh(input logic [31:0] k);
    logic [31:0] p;
    p = k * 32'h9E3779B1;
    return p[31 -: HB];
  endfunction

  task automatic insert(input logic [31:0] k, input logic [31:0] bp);
    nk[n_nodes] = k;
    np[n_nodes] = bp;
    nn[n_nodes] = head_t[hsh(k)];
    head_t[hsh(k)] = NBASE + 32'(12 * n_nodes);
    n_nodes++;
  endtask

  task automatic exp_push(input logic [31:0] k, input logic [31:0] p);
    logic [31:0] ptr;
    int idx;
    ptr = head_t[hsh(k)];
    while (ptr != 0) begin
      idx = int'((ptr - NBASE) / 12);
      if (nk[idx] == k) expq.push_back({k, p, np[idx]});
      ptr = nn[idx];
    end
  endtask

  task automatic send(input logic [31:0] k, input logic [31:0] p);
    @(negedge clk);
    in_valid = 1; in_key = k; in_pay = p;
    do @(posedge clk); while (!in_ready);
    exp_push(k, p);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic drain(input string req);
    repeat (400) @(negedge clk);
    chk(expq.size() == 0, req, 96'(expq.size()), 96'd0);
  endtask

  // memory model: random latency, out-of-order return
  bit sv [16];
  logic [2:0] stg [16];
  logic [31:0] sa [16];
  bit sn [16];
  int sd [16];
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) begin
    int idx;
    bit found;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (!rst_n) begin
      mem_req_ready <= 1;
      out_ready <= 1;
      mem_rsp_valid <= 0;
      mem_rsp_tag <= 0;
      mem_rsp_data <= 0;
      for (int i = 0; i < 16; i++) sv[i] = 0;
    end else begin
      if (mem_req_valid && mem_req_ready) begin
        if (!mem_req_node)
          chk(in_valid && mem_req_addr == TBASE + 32'(hsh(in_key)) * 4, "R1 head address",
              96'(mem_req_addr), 96'(TBASE + 32'(hsh(in_key)) * 4));
        else
          chk(mem_req_addr >= NBASE && (mem_req_addr - NBASE) % 12 == 0
              && mem_req_addr < NBASE + 12 * NN, "R3 node address",
              96'(mem_req_addr), 96'(NBASE));
        found = 0;
        for (int i = 0; i < 16; i++)
          if (!sv[i] && !found) begin
            found = 1; sv[i] = 1; stg[i] = mem_req_tag; sa[i] = mem_req_addr;
            sn[i] = mem_req_node; sd[i] = 1 + int'(lfsr[2:0]);
          end
      end
      mem_rsp_valid <= 0;
      found = 0;
      for (int i = 15; i >= 0; i--)
        if (sv[i] && sd[i] > 0) sd[i]--;
      for (int i = 0; i < 16; i++)
        if (sv[i] && sd[i] == 0 && !found && !freeze) begin
          found = 1; sv[i] = 0;
          mem_rsp_valid <= 1;
          mem_rsp_tag <= stg[i];
          if (sn[i]) begin
            idx = int'((sa[i] - NBASE) / 12);
            mem_rsp_data <= {nn[idx], np[idx], nk[idx]};
          end else begin
            mem_rsp_data <= {64'd0, head_t[(sa[i] - TBASE) >> 2]};
          end
        end
      mem_req_ready <= rdy_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
      out_ready <= out_rand ? (lfsr[5] | lfsr[9]) : 1'b1;
    end
  end

  // scoreboard monitor
  bit prev_stall = 0;
  logic [95:0] prev_out;
  bit rsp_seen = 0;
  always @(posedge clk) begin
    bit found;
    if (rst_n) begin
      if (prev_stall)
        chk(out_valid && {out_key, out_probe_pay, out_build_pay} == prev_out,
            "R11 stalled output held", {out_key, out_probe_pay, out_build_pay}, prev_out);
      prev_stall = out_valid && !out_ready;
      prev_out = {out_key, out_probe_pay, out_build_pay};
      if (out_valid && out_ready) begin
        n_out++;
        found = 0;
        foreach (expq[i])
          if (!found && expq[i] == {out_key, out_probe_pay, out_build_pay}) begin
            found = 1;
            expq.delete(i);
          end
        chk(found, "R4/R5/R9 unexpected join", {out_key, out_probe_pay, out_build_pay}, 96'd0);
      end
      rsp_seen = mem_rsp_valid;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_seen) chk(!in_ready, "R7 recycled priority", 96'(in_ready), 96'd0);
      if (!mem_req_ready) chk(!in_ready, "R12 intake gated by memory", 96'(in_ready), 96'd0);
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 0);
    finish_run();
  end

  initial begin
    logic [31:0] ek;
    int acc, outs0;
    for (int i = 0; i < NB; i++) head_t[i] = 0;
    for (int i = 0; i < 12; i++) insert(32'd100 + i, 32'hB000 + i);
    insert(32'd105, 32'hB100);
    insert(32'd105, 32'hB101);
    insert(32'd200, 32'hB200);
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid, "R10 out_valid after reset", 96'(out_valid), 0);
    chk(!mem_req_valid, "R10 mem_req_valid after reset", 96'(mem_req_valid), 0);
    chk(in_ready, "R10 in_ready after reset", 96'(in_ready), 1);

    // R1 R4 R5 R6: each key, duplicates on one chain, absent key in a used bucket
    for (int i = 0; i < 12; i++) send(32'd100 + i, 32'hA000 + i);
    send(32'd105, 32'hA105);
    send(32'd200, 32'hA200);
    send(32'd300, 32'hA300);
    drain("R5/R6 all joins emitted");

    // R2: key whose bucket is empty
    ek = 32'd5000;
    while (head_t[hsh(ek)] != 0) ek++;
    outs0 = n_out;
    send(ek, 32'hDEAD);
    drain("R2 empty bucket");
    chk(n_out == outs0, "R2 no output for empty bucket", 96'(n_out - outs0), 0);

    // R9 R11 R12: random back-pressure and out-of-order returns
    rdy_rand = 1; out_rand = 1;
    for (int i = 0; i < 60; i++) begin
      int r = $urandom_range(0, 15);
      send(r < 12 ? 32'd100 + 32'(r) : (r == 12 ? 32'd200 : (r == 13 ? ek : 32'd105)),
           32'hC000 + 32'(i));
    end
    drain("R9 out-of-order joins emitted");
    rdy_rand = 0; out_rand = 0;

    // R8: freeze memory until all threads are busy
    freeze = 1;
    acc = 0;
    @(negedge clk);
    in_valid = 1;
    for (int i = 0; i < 20; i++) begin
      in_key = 32'd100 + 32'(i % 12);
      in_pay = 32'hE000 + 32'(i);
      @(posedge clk);
      if (in_ready) begin
        acc++;
        exp_push(in_key, in_pay);
      end
      @(negedge clk);
    end
    chk(acc == THREADS, "R8 thread limit", 96'(acc), 96'(THREADS));
    chk(!in_ready, "R8 intake stalled when full", 96'(in_ready), 0);
    in_valid = 0;
    freeze = 0;
    drain("R8 frozen joins emitted");
    chk(in_ready, "R6 threads reusable after retire", 96'(in_ready), 1);
    send(32'd105, 32'hF105);
    drain("R6 reuse join emitted");
    finish_run();
  end
endmodule